// File: doc/BRIEF.md
# Ethernet Pause Frame Detector

This block watches the byte stream of a received Ethernet frame, with preamble already removed, and decides whether the frame is a valid flow-control pause request. It compares the destination address with a programmable station address and with the reserved flow-control multicast address. It checks the MAC-control type and the pause opcode, and it captures the 16-bit pause quantum that follows them. When a frame ends cleanly, the block reports the frame through one-cycle strobes. The first strobe is a received pulse. The second is an interrupt request gated by an enable input. The third is a timer-load strobe that carries the captured pause value. The block also keeps a saturating count of accepted pause frames.

The receive path supplies a frame-error flag with the end-of-frame strobe, and an error there cancels every output of that frame. The received pulse and the interrupt are raised whatever the duplex setting. The timer-load strobe is raised only when the port runs in full duplex.

Top module: `pause_frame_detect`

## Requirements
- R1: A frame whose bytes 0..5 equal `station_addr`, most significant byte first, passes the address check.
- R2: A frame whose bytes 0..5 are 01-80-C2-00-00-01 passes the address check whatever the value of `station_addr`.
- R3: A frame whose destination matches neither address raises no output strobe and leaves the counter unchanged.
- R4: Bytes 12 and 13 must be 0x88 and then 0x08, or the frame is rejected.
- R5: Bytes 14 and 15 must be 0x00 and then 0x01, or the frame is rejected.
- R6: Bytes 16 (high) and 17 (low) form the pause value, which appears on `pause_value` when a frame is accepted and holds until the next accepted frame.
- R7: If `rx_err` is high with `rx_eof`, the frame produces no strobe and no count.
- R8: A frame that ends with fewer than 18 bytes is rejected.
- R9: `pause_frame_cnt` rises by one for each accepted frame and saturates at all ones. Its width is set by `CNT_W`, which defaults to 16.
- R10: `pause_rcvd` pulses for every accepted frame in either duplex mode. `pause_irq` pulses with it only when `irq_en` is high.
- R11: `pause_load` pulses for an accepted frame only when `cfg_full_duplex` is high.
- R12: After reset all strobes and the counter are zero. Each strobe lasts one cycle and appears in the cycle after the `rx_eof` cycle.
- R13: Bytes after byte 17, and cycles with `rx_valid` low inside a frame, do not affect the outcome or the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Marks the first byte of a frame; valid together with rx_valid |
| rx_valid | input | 1 | rx_data holds a frame byte |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe; carries no byte |
| rx_err | input | 1 | Frame error flag, sampled with rx_eof |
| station_addr | input | 48 | Programmable station address, first byte in bits 47:40 |
| cfg_full_duplex | input | 1 | High when the port runs full duplex |
| irq_en | input | 1 | Enable for the interrupt request |
| pause_rcvd | output | 1 | One-cycle pulse for each accepted pause frame |
| pause_irq | output | 1 | Interrupt request pulse, gated by irq_en |
| pause_load | output | 1 | Pause-timer load strobe, full duplex only |
| pause_value | output | 16 | Captured pause quantum |
| pause_frame_cnt | output | CNT_W | Saturating count of accepted pause frames |

## Verification
The hardest case to reach is counter saturation, because with the default width it would take 65535 frames. The bench therefore builds the block with a 4-bit counter and sends multicast pause frames until the count reaches all ones. It then sends one more frame and checks that the count holds while the received pulse still fires. A second hard case is a frame whose header is correct but ends too early. The bench sends a 17-byte frame straight after a valid one, so that field flags left over from the earlier frame would wrongly let it pass if the length check were missing.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam logic [47:0] PFD_MC_ADDR = 48'h0180C2000001;
  localparam logic [15:0] PFD_TYPE    = 16'h8808;
  localparam logic [15:0] PFD_OPCODE  = 16'h0001;
  localparam int DA_LEN   = 6;
  localparam int TYPE_OFS = 12;
  localparam int OPC_OFS  = 14;
  localparam int TIME_OFS = 16;
  localparam int HDR_LEN  = 18;
  localparam int IDX_W    = $clog2(HDR_LEN + 1);
endpackage

// File: rtl/pfd_field_track.sv
module pfd_field_track
  import pfd_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic [47:0] station_addr,
  output logic        hdr_ok,
  output logic [15:0] time_q
);
  logic          in_frame;
  logic [IW-1:0] idx, pos;
  logic          fire;
  logic          uc_ok, mc_ok, ty_ok, op_ok;
  logic [7:0]    uc_byte, mc_byte;

  assign fire = rx_valid && !rx_eof && (rx_sof || in_frame);
  assign pos  = rx_sof ? '0 : idx;

  // select the expected destination byte for the current position
  always_comb begin
    uc_byte = '0;
    mc_byte = '0;
    for (int k = 0; k < DA_LEN; k++) begin
      if (pos == IW'(k)) begin
        uc_byte = station_addr[8*(DA_LEN-1-k) +: 8];
        mc_byte = PFD_MC_ADDR[8*(DA_LEN-1-k) +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      idx      <= '0;
      uc_ok    <= 1'b0;
      mc_ok    <= 1'b0;
      ty_ok    <= 1'b0;
      op_ok    <= 1'b0;
      time_q   <= '0;
    end else if (rx_eof) begin
      in_frame <= 1'b0;
    end else if (fire) begin
      in_frame <= 1'b1;
      if (pos < IW'(HDR_LEN)) idx <= pos + 1'b1;
      else                    idx <= pos;
      if (pos == '0) begin
        uc_ok <= (rx_data == uc_byte);
        mc_ok <= (rx_data == mc_byte);
      end else if (pos < IW'(DA_LEN)) begin
        uc_ok <= uc_ok && (rx_data == uc_byte);
        mc_ok <= mc_ok && (rx_data == mc_byte);
      end
      if (pos == IW'(TYPE_OFS))     ty_ok <= (rx_data == PFD_TYPE[15:8]);
      if (pos == IW'(TYPE_OFS + 1)) ty_ok <= ty_ok && (rx_data == PFD_TYPE[7:0]);
      if (pos == IW'(OPC_OFS))      op_ok <= (rx_data == PFD_OPCODE[15:8]);
      if (pos == IW'(OPC_OFS + 1))  op_ok <= op_ok && (rx_data == PFD_OPCODE[7:0]);
      if (pos == IW'(TIME_OFS))     time_q[15:8] <= rx_data;
      if (pos == IW'(TIME_OFS + 1)) time_q[7:0]  <= rx_data;
    end
  end

  assign hdr_ok = in_frame && (uc_ok || mc_ok) && ty_ok && op_ok &&
                  (idx == IW'(HDR_LEN));
endmodule

// File: rtl/pfd_sat_counter.sv
module pfd_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (inc && count != MAX)  count <= count + 1'b1;
  end
endmodule

// File: rtl/pfd_result.sv
module pfd_result (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic        hdr_ok,
  input  logic [15:0] time_q,
  input  logic        full_dup,
  input  logic        irq_en,
  output logic        accept,
  output logic        rcvd_q,
  output logic        irq_q,
  output logic        load_q,
  output logic [15:0] value_q
);
  assign accept = rx_eof && !rx_err && hdr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcvd_q  <= 1'b0;
      irq_q   <= 1'b0;
      load_q  <= 1'b0;
      value_q <= '0;
    end else begin
      rcvd_q <= accept;
      irq_q  <= accept && irq_en;
      load_q <= accept && full_dup;
      if (accept) value_q <= time_q;
    end
  end
endmodule

// File: rtl/pause_frame_detect.sv
module pause_frame_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_sof,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_eof,
  input  logic             rx_err,
  input  logic [47:0]      station_addr,
  input  logic             cfg_full_duplex,
  input  logic             irq_en,
  output logic             pause_rcvd,
  output logic             pause_irq,
  output logic             pause_load,
  output logic [15:0]      pause_value,
  output logic [CNT_W-1:0] pause_frame_cnt
);
  logic        hdr_ok;
  logic [15:0] time_q;
  logic        accept;

  pfd_field_track u_track (
    .clk          (clk),
    .rst          (rst),
    .rx_sof       (rx_sof),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_eof       (rx_eof),
    .station_addr (station_addr),
    .hdr_ok       (hdr_ok),
    .time_q       (time_q)
  );

  pfd_result u_result (
    .clk      (clk),
    .rst      (rst),
    .rx_eof   (rx_eof),
    .rx_err   (rx_err),
    .hdr_ok   (hdr_ok),
    .time_q   (time_q),
    .full_dup (cfg_full_duplex),
    .irq_en   (irq_en),
    .accept   (accept),
    .rcvd_q   (pause_rcvd),
    .irq_q    (pause_irq),
    .load_q   (pause_load),
    .value_q  (pause_value)
  );

  pfd_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (accept),
    .count (pause_frame_cnt)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_eof,
  input logic             rx_err,
  input logic             cfg_full_duplex,
  input logic             irq_en,
  input logic             pause_rcvd,
  input logic             pause_irq,
  input logic             pause_load,
  input logic [CNT_W-1:0] pause_frame_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R12
  rcvd_single_chk: assert property (@(posedge clk) disable iff (rst)
    pause_rcvd |=> !pause_rcvd);

  // R7
  rcvd_clean_eof_chk: assert property (@(posedge clk) disable iff (rst)
    pause_rcvd |-> $past(rx_eof && !rx_err));

  // R11
  load_fd_only_chk: assert property (@(posedge clk) disable iff (rst)
    pause_load |-> (pause_rcvd && $past(cfg_full_duplex)));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    pause_irq |-> (pause_rcvd && $past(irq_en)));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pause_rcvd && $past(pause_frame_cnt) != CMAX) |->
      pause_frame_cnt == $past(pause_frame_cnt) + 1'b1);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pause_rcvd |-> $stable(pause_frame_cnt));
endmodule

bind pause_frame_detect pfd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .rx_eof          (rx_eof),
  .rx_err          (rx_err),
  .cfg_full_duplex (cfg_full_duplex),
  .irq_en          (irq_en),
  .pause_rcvd      (pause_rcvd),
  .pause_irq       (pause_irq),
  .pause_load      (pause_load),
  .pause_frame_cnt (pause_frame_cnt)
);

// File: tb/pause_frame_detect_tb.sv
module pause_frame_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam logic [47:0] STA = 48'h02AB_CD12_3456;
  localparam logic [47:0] MCA = 48'h0180_C200_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_sof = 0, rx_valid = 0, rx_eof = 0, rx_err = 0;
  logic [7:0] rx_data = '0;
  logic [47:0] station_addr = STA;
  logic cfg_full_duplex = 0, irq_en = 0;
  logic pause_rcvd, pause_irq, pause_load;
  logic [15:0] pause_value;
  logic [CW-1:0] pause_frame_cnt;

  int checks = 0;
  int fails = 0;
  logic [CW-1:0] exp_cnt = '0;
  logic [15:0] exp_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_frame_detect #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
    .station_addr(station_addr), .cfg_full_duplex(cfg_full_duplex),
    .irq_en(irq_en), .pause_rcvd(pause_rcvd), .pause_irq(pause_irq),
    .pause_load(pause_load), .pause_value(pause_value),
    .pause_frame_cnt(pause_frame_cnt)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k, input logic [47:0] da,
                                       input logic [15:0] ty, input logic [15:0] op,
                                       input logic [15:0] tm);
    if (k < 6)        return da[8*(5-k) +: 8];
    else if (k < 12)  return 8'h60 + 8'(k);
    else if (k == 12) return ty[15:8];
    else if (k == 13) return ty[7:0];
    else if (k == 14) return op[15:8];
    else if (k == 15) return op[7:0];
    else if (k == 16) return tm[15:8];
    else if (k == 17) return tm[7:0];
    else              return 8'hC3 ^ 8'(k);
  endfunction

  // drive one frame, then check all outputs one cycle after rx_eof
  task automatic run_case(input string tag, input logic [47:0] da,
                          input logic [15:0] ty, input logic [15:0] op,
                          input logic [15:0] tm, input int len, input bit err,
                          input bit gaps, input bit fd, input bit ien, input bit ok);
    cfg_full_duplex = fd;
    irq_en = ien;
    for (int k = 0; k < len; k++) begin
      if (gaps && (k % 5 == 3)) begin
        @(negedge clk);
        rx_sof = 0; rx_valid = 0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_sof = (k == 0); rx_valid = 1; rx_data = fbyte(k, da, ty, op, tm);
    end
    @(negedge clk);
    rx_sof = 0; rx_valid = 0; rx_eof = 1; rx_err = err;
    @(negedge clk);
    rx_eof = 0; rx_err = 0;
    if (ok) begin
      exp_val = tm;
      if (exp_cnt != '1) exp_cnt = exp_cnt + 1'b1;
    end
    chk({tag, " rcvd"}, 48'(pause_rcvd), 48'(ok));
    chk({tag, " irq"}, 48'(pause_irq), 48'(ok && ien));
    chk({tag, " load"}, 48'(pause_load), 48'(ok && fd));
    chk({tag, " value"}, 48'(pause_value), 48'(exp_val));
    chk({tag, " count"}, 48'(pause_frame_cnt), 48'(exp_cnt));
    @(negedge clk);
    chk({tag, " R12 pulse width"}, 48'(pause_rcvd), 48'd0);
  endtask

  task automatic t_reset();
    chk("R12 reset rcvd", 48'(pause_rcvd), 0);
    chk("R12 reset irq", 48'(pause_irq), 0);
    chk("R12 reset load", 48'(pause_load), 0);
    chk("R12 reset count", 48'(pause_frame_cnt), 0);
  endtask

  task automatic t_unicast();
    run_case("R1 R6 R11 unicast fd", STA, 16'h8808, 16'h0001, 16'hBEEF, 18, 0, 0, 1, 1, 1);
  endtask

  task automatic t_multicast_hd();
    run_case("R2 R10 R11 multicast hd", MCA, 16'h8808, 16'h0001, 16'h1234, 20, 0, 0, 0, 1, 1);
  endtask

  task automatic t_bad_da();
    run_case("R3 wrong da", STA ^ 48'h1, 16'h8808, 16'h0001, 16'h5555, 18, 0, 0, 1, 1, 0);
    run_case("R3 mixed da", {MCA[47:8], STA[7:0]}, 16'h8808, 16'h0001, 16'h5555, 18, 0, 0, 1, 1, 0);
  endtask

  task automatic t_bad_type();
    run_case("R4 ip type", STA, 16'h0800, 16'h0001, 16'h7777, 18, 0, 0, 1, 1, 0);
    run_case("R4 low type byte", STA, 16'h8809, 16'h0001, 16'h7777, 18, 0, 0, 1, 1, 0);
  endtask

  task automatic t_bad_opcode();
    run_case("R5 opcode", MCA, 16'h8808, 16'h0002, 16'h7777, 18, 0, 0, 1, 1, 0);
  endtask

  task automatic t_error();
    run_case("R7 rx_err", STA, 16'h8808, 16'h0001, 16'h4242, 64, 1, 0, 1, 1, 0);
  endtask

  task automatic t_short();
    run_case("R8 valid before short", MCA, 16'h8808, 16'h0001, 16'h0A0B, 18, 0, 0, 1, 1, 1);
    run_case("R8 short frame", MCA, 16'h8808, 16'h0001, 16'h0A0B, 17, 0, 0, 1, 1, 0);
  endtask

  task automatic t_long_gaps();
    run_case("R13 long gapped", STA, 16'h8808, 16'h0001, 16'hFFFE, 64, 0, 1, 1, 1, 1);
  endtask

  task automatic t_masked();
    run_case("R10 irq masked", MCA, 16'h8808, 16'h0001, 16'h0003, 18, 0, 0, 1, 0, 1);
  endtask

  task automatic t_saturate();
    while (exp_cnt != '1)
      run_case("R9 fill", MCA, 16'h8808, 16'h0001, 16'h0100, 18, 0, 0, 1, 1, 1);
    run_case("R9 saturate", MCA, 16'h8808, 16'h0001, 16'h0200, 18, 0, 0, 1, 1, 1);
    chk("R9 stays at max", 48'(pause_frame_cnt), 48'(4'hF));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_multicast_hd();
    t_bad_da();
    t_bad_type();
    t_bad_opcode();
    t_error();
    t_short();
    t_long_gaps();
    t_masked();
    t_saturate();
    finish_run();
  end
endmodule